// File: doc/BRIEF.md
# Caption Line Serializer

This block places closed-caption data on one chosen video line of every field. Software fills four byte registers through a small write port. Two bytes are caption data for the odd field, and two are extended data for the even field. On the caption line the block sends one frame, bit cell by bit cell, as a single-bit level with a valid flag. A later analog stage shapes that level into the line waveform.

The frame begins with a clock run-in of seven high/low cycles. A three-cell framing code follows, and then the two data bytes of the selected field, each sent least significant bit first. The top bit of each byte is the parity bit. Software computes it, and the block sends it as written. The caption line number, the delay from line start to the first cell and the cell width in pixel clocks are all parameters. A field-start pulse and line-start pulses drive the block's line count. The field level is sampled when the caption line begins, and all four bytes are captured at that moment. A register write made while a frame is on the line therefore only reaches the frame of a later field.

Top module: `cc_line21_serializer`

## Requirements
- R1: After reset, `serValid` and `serOut` are low and all four data registers read as zero, so a frame sent before any write carries zero data bits.
- R2: A frame is started only by the line-start pulse of line CAP_LINE, counted from 1 after the last field-start pulse. Line-start pulses of other lines leave `serValid` low.
- R3: `serValid` rises exactly START_DELAY clock cycles after the clock edge that samples the caption line's start pulse.
- R4: Cells 0 to 13 of the frame are the run-in: cell n is 1 for even n and 0 for odd n.
- R5: Cells 14, 15 and 16 carry the framing code 0, 0, 1.
- R6: Cells 17 to 24 carry the first byte and cells 25 to 32 the second byte, each least significant bit first, with bit 7 (parity) sent unchanged.
- R7: `fieldOdd` is sampled with the caption line's start pulse. A value of 1 selects register addresses 0 (first byte) and 1 (second byte). A value of 0 selects addresses 2 (first byte) and 3 (second byte).
- R8: Every cell lasts CELL_CLKS clock cycles, and a frame has exactly 33 cells, after which `serValid` falls.
- R9: A register write made while a frame is in progress does not change that frame. It is sent in the next frame that selects the register.
- R10: While `serValid` is low, `serOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0/1 odd-field bytes, 2/3 even-field bytes |
| wrData | input | 8 | Byte to write, parity in bit 7 |
| fieldStart | input | 1 | Pulse that restarts the line count of a field |
| lineStart | input | 1 | Pulse at the start of every line |
| fieldOdd | input | 1 | Field level, 1 for the odd field |
| serOut | output | 1 | Serial cell level |
| serValid | output | 1 | High while a frame is on the line |

## Verification
The bench sends a frame for both field levels over a sweep of byte patterns. The patterns include all-zero registers after reset, walking ones against walking zeros and bytes with the parity bit set and clear. It compares every clock cycle with a frame model computed from cell timing. Walking patterns catch bit-order and byte-swap faults, and the different odd and even contents catch a wrong pair selection. Line-start pulses on other lines and the cycles around the start delay check the gating and the timing edges. A mid-frame write followed by a second field of the same parity tells apart capturing the bytes at line start from reading them live.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  localparam int FRAME_BITS = 33;
  localparam int RUNIN_BITS = 14;

  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_SEND} ccState_e;

  typedef struct packed {
    logic load;
    logic shift;
  } ccStrobe_t;

  function automatic logic [RUNIN_BITS-1:0] runInPattern();
    logic [RUNIN_BITS-1:0] v;
    for (int i = 0; i < RUNIN_BITS; i++) v[i] = (i % 2 == 0);
    return v;
  endfunction
endpackage

// File: rtl/cc_ctrl.sv
`timescale 1ns/1ps
module cc_ctrl
  import cc_pkg::*;
#(
  parameter int CAP_LINE    = 21,
  parameter int START_DELAY = 100,
  parameter int CELL_CLKS   = 54
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fieldStart,
  input  logic      lineStart,
  output ccStrobe_t strb,
  output logic      serValid
);
  localparam int LINE_W = $clog2(CAP_LINE + 1) + 1;
  localparam int DLY_W  = (START_DELAY > 1) ? $clog2(START_DELAY) : 1;
  localparam int CELL_W = (CELL_CLKS > 1) ? $clog2(CELL_CLKS) : 1;
  localparam int BIT_W  = $clog2(FRAME_BITS);
  localparam logic [LINE_W-1:0] LINE_HIT  = LINE_W'(CAP_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_MAX  = {LINE_W{1'b1}};
  localparam logic [DLY_W-1:0]  DLY_LAST  = DLY_W'(START_DELAY - 1);
  localparam logic [CELL_W-1:0] CELL_LAST = CELL_W'(CELL_CLKS - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_BITS - 1);

  ccState_e          state;
  logic [LINE_W-1:0] lineCnt;
  logic [DLY_W-1:0]  dlyCnt;
  logic [CELL_W-1:0] cellCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              startHit;
  logic              cellEnd;

  assign startHit = lineStart && !fieldStart && (lineCnt == LINE_HIT) && (state == ST_IDLE);
  assign cellEnd  = (state == ST_SEND) && (cellCnt == CELL_LAST);
  assign strb.load  = startHit;
  assign strb.shift = cellEnd;
  assign serValid   = (state == ST_SEND);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= '0;
    end else if (fieldStart) begin
      lineCnt <= '0;
    end else if (lineStart && lineCnt != LINE_MAX) begin
      lineCnt <= lineCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dlyCnt  <= '0;
      cellCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startHit) begin
            state  <= ST_DELAY;
            dlyCnt <= '0;
          end
        end
        ST_DELAY: begin
          if (dlyCnt == DLY_LAST) begin
            state   <= ST_SEND;
            cellCnt <= '0;
            bitCnt  <= '0;
          end else begin
            dlyCnt <= dlyCnt + 1'b1;
          end
        end
        ST_SEND: begin
          if (cellEnd) begin
            cellCnt <= '0;
            if (bitCnt == BIT_LAST) state <= ST_IDLE;
            else bitCnt <= bitCnt + 1'b1;
          end else begin
            cellCnt <= cellCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: the start delay always leads into sending
  p_delay_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DELAY |=> (state == ST_DELAY || state == ST_SEND));
  // R8: cell counter never passes the cell width
  p_cell_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SEND |-> cellCnt <= CELL_LAST);
  // R8: a frame ends only after its last cell
  p_frame_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serValid) |-> $past(bitCnt) == BIT_LAST);
  // R2: no new frame while one is pending
  p_no_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    state != ST_IDLE |=> !$rose(state == ST_DELAY));
endmodule

// File: rtl/cc_datapath.sv
`timescale 1ns/1ps
module cc_datapath
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       fieldOdd,
  input  ccStrobe_t  strb,
  output logic       serBit
);
  localparam logic [RUNIN_BITS-1:0] RUNIN = runInPattern();
  localparam logic [2:0] FRAMING = 3'b100; // sent 0, 0, 1

  logic [7:0]            capReg [4];
  logic [FRAME_BITS-1:0] shiftReg;
  logic [7:0]            selFirst;
  logic [7:0]            selSecond;

  always_comb begin
    selFirst  = fieldOdd ? capReg[0] : capReg[2];
    selSecond = fieldOdd ? capReg[1] : capReg[3];
  end

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : gRegs
      always_ff @(posedge clk) begin
        if (!rstN) capReg[g] <= '0;
        else if (wrEn && wrAddr == 2'(g)) capReg[g] <= wrData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.load) begin
      shiftReg <= {selSecond, selFirst, FRAMING, RUNIN};
    end else if (strb.shift) begin
      shiftReg <= {1'b0, shiftReg[FRAME_BITS-1:1]};
    end
  end

  assign serBit = shiftReg[0];

  // R9: the captured frame changes only on load or cell end
  p_hold_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load && !strb.shift |=> $stable(shiftReg));
  // R7: odd field capture takes the odd pair
  p_odd_pick_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && fieldOdd |=> shiftReg[FRAME_BITS-1 -: 16] == {$past(capReg[1]), $past(capReg[0])});
endmodule

// File: rtl/cc_line21_serializer.sv
`timescale 1ns/1ps
module cc_line21_serializer
  import cc_pkg::*;
#(
  parameter int CAP_LINE    = 21,
  parameter int START_DELAY = 100,
  parameter int CELL_CLKS   = 54
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       fieldStart,
  input  logic       lineStart,
  input  logic       fieldOdd,
  output logic       serOut,
  output logic       serValid
);
  ccStrobe_t strb;
  logic      serBit;

  cc_ctrl #(
    .CAP_LINE(CAP_LINE), .START_DELAY(START_DELAY), .CELL_CLKS(CELL_CLKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .lineStart(lineStart),
    .strb(strb), .serValid(serValid)
  );

  cc_datapath uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .fieldOdd(fieldOdd), .strb(strb), .serBit(serBit)
  );

  assign serOut = serValid & serBit;

  // R10: the line stays low outside a frame
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !serValid |-> !serOut);
  // R3: a frame never starts on the capture edge
  p_start_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !serValid);
endmodule

// File: tb/tb_cc_line21_serializer.sv
`timescale 1ns/1ps
module tb_cc_line21_serializer;
  localparam int CAP   = 3;
  localparam int DLY   = 3;
  localparam int CELL  = 4;
  localparam int CELLS = 33;

  logic clk = 0;
  logic rstN = 0;
  logic wrEn = 0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic fieldStart = 0, lineStart = 0, fieldOdd = 0;
  logic serOut, serValid;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] model [4];

  always #2.5 clk = ~clk;

  cc_line21_serializer #(.CAP_LINE(CAP), .START_DELAY(DLY), .CELL_CLKS(CELL)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .fieldStart(fieldStart), .lineStart(lineStart), .fieldOdd(fieldOdd),
    .serOut(serOut), .serValid(serValid)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expBit(int k, logic [7:0] b0, logic [7:0] b1);
    if (k < 14) return (k % 2 == 0);
    if (k < 16) return 1'b0;
    if (k == 16) return 1'b1;
    if (k < 25) return b0[k-17];
    return b1[k-25];
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    wrEn = 1; wrAddr = 2'(a); wrData = d;
    step();
    wrEn = 0;
    model[a] = d;
  endtask

  task automatic idleLine();
    lineStart = 1;
    step();
    lineStart = 0;
    for (int i = 0; i < 5; i++) begin
      check(serValid == 0, "R2 off-line valid", serValid, 0);
      step();
    end
  endtask

  task automatic runField(bit odd, bit midWr, int mwAddr, logic [7:0] mwData);
    logic [7:0] b0, b1;
    fieldStart = 1;
    step();
    fieldStart = 0;
    for (int l = 1; l < CAP; l++) idleLine();
    b0 = odd ? model[0] : model[2];
    b1 = odd ? model[1] : model[3];
    fieldOdd = odd;
    lineStart = 1;
    step();
    lineStart = 0;
    fieldOdd = ~odd;
    for (int n = 0; n < DLY + CELLS*CELL + 3; n++) begin
      if (n < DLY) begin
        check(serValid == 0, "R3 delay", serValid, 0);
      end else if (n >= DLY + CELLS*CELL) begin
        check(serValid == 0, "R8 frame end", serValid, 0);
      end else begin
        int k = (n - DLY) / CELL;
        logic e = expBit(k, b0, b1);
        check(serValid == 1, "R8 valid span R3", serValid, 1);
        if (k < 14)      check(serOut == e, "R4 run-in", serOut, e);
        else if (k < 17) check(serOut == e, "R5 framing", serOut, e);
        else             check(serOut == e, midWr ? "R9 held frame R6 R7" : "R6 R7 data", serOut, e);
      end
      if (!serValid) check(serOut == 0, "R10 idle low", serOut, 0);
      if (midWr && n == DLY + 10) begin
        wr(mwAddr, mwData);
      end else begin
        step();
      end
    end
    idleLine();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    @(negedge clk);
    step(); step();
    rstN = 1;
    check(serValid == 0, "R1 reset valid", serValid, 0);
    check(serOut == 0, "R1 reset out", serOut, 0);
    runField(1, 0, 0, 8'h00); // R1: zero registers after reset
    runField(0, 0, 0, 8'h00);
    for (int i = 0; i < 8; i++) begin
      wr(0, 8'h01 << i);
      wr(1, ~(8'h01 << i));
      wr(2, 8'((i * 37 + 5) ^ 8'h80));
      wr(3, 8'(i * 91 + 17));
      runField(1, 0, 0, 8'h00);
      runField(0, 0, 0, 8'h00);
    end
    wr(0, 8'hA5); wr(1, 8'h5A); wr(2, 8'hC3); wr(3, 8'h3C);
    runField(1, 1, 0, 8'h96);   // R9: write mid-frame, old value expected
    runField(0, 1, 3, 8'hE1);
    runField(1, 0, 0, 8'h00);   // R9: new value now sent
    runField(0, 0, 0, 8'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule